// File: doc/BRIEF.md
# Multiplexor Event Flag Scanner

This block collects the events of a bank of serial lines, one flag per line and per event kind, and hands them to a processor one at a time. Each line can raise four kinds of event: a character was received, a transmission finished, carrier came up, and carrier went away. A round-robin search picks the next pending flag after the one serviced last and locks onto it. The block then raises the one interrupt request output that belongs to that event kind.

The processor answers by strobing a read. The read word it sees carries the line number. For a receive event, the word also carries the character held for that line and an overrun indication. The read clears the serviced flag and releases the lock. One cycle later the search resumes from the flag after the one just serviced. The line count must be a power of two.

Top module: `muxirq_scanner`

## Requirements
- R1: After reset no interrupt request is raised and the read word is zero until a new event strobe arrives. Reset discards every pending flag and all receive status, and sets the search pointer to flag 0.
- R2: Flag index is line*4 + kind, with kind 0 = receive, 1 = transmit done, 2 = carrier on, 3 = carrier off. When the scanner locks on a flag it raises irq_o[kind]. For a strobe sampled by clock edge k on an idle scanner, the request is high after edge k+1.
- R3: At most one interrupt request is high at a time. While locked, the request and the read word's line field stay fixed until a read is accepted. Strobes that arrive during the lock are recorded and serviced later.
- R4: A search tests flags starting at pointer+1 and wraps modulo the flag count. The pointer's own flag is tested last. The located flag becomes the new pointer.
- R5: The read word holds the line number in bits 4:0. For transmit-done and carrier events every other bit is zero.
- R6: For a receive event the read word also holds the line's held character in bits 23:16 and the line's overrun flag in bit 15.
- R7: A read strobe during a lock is accepted on that edge. The request drops after that edge and the serviced flag is cleared. The scanner stays idle for one cycle and then searches again, so the next pending event raises its request after the second edge counted from the read.
- R8: A receive strobe while the line already holds an unread character sets that line's overrun flag and replaces the held character with the new one. Accepting a receive-kind read clears the line's pending and overrun status.
- R9: Strobes for any number of flags in the same cycle are all recorded.
- R10: When a strobe targets the flag being cleared by a read in the same cycle, the flag stays set. For a receive strobe, the clear applies first: the new character is pending with no overrun.
- R11: A read strobe while no request is raised has no effect, and does not delay the search that runs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_stb_i | input | 32 | Per-line character-received strobe |
| rx_char_i | input | 256 | Per-line received character, line l in bits 8l+7:8l |
| tx_done_i | input | 32 | Per-line transmit-done strobe |
| carr_on_i | input | 32 | Per-line carrier-up strobe |
| carr_off_i | input | 32 | Per-line carrier-down strobe |
| rd_stb_i | input | 1 | Processor read of the event word |
| rd_word_o | output | 24 | Event word: line, character, overrun |
| irq_o | output | 4 | Interrupt request per event kind |

## Verification
The bench targets the wrap of the round-robin search. The flag at the pointer must be found only after every other flag, so a search that started at the pointer itself would service the same line twice. It drives a strobe into the very flag a read is clearing: a design that let the clear win would drop that event. It also drives a second receive before a read, since a wrong status update would either lose the overrun or carry it into the next character. A read held high into the idle cycle after a service must not push the next lock back by a cycle, and events arriving during a lock must neither disturb the raised request nor be lost.

// File: rtl/muxirq_pkg.sv
`timescale 1ns/1ps
package muxirq_pkg;

    // event kinds; the value is also the low part of a flag index
    typedef enum logic [1:0] {
        EV_RX       = 2'd0,
        EV_TX       = 2'd1,
        EV_CARR_ON  = 2'd2,
        EV_CARR_OFF = 2'd3
    } evt_e;

    localparam int EVT_TYPES = 4;
    localparam int TYPE_W    = 2;

    // read word field placement
    localparam int CHAR_LSB  = 16;
    localparam int OVR_BIT   = 15;

endpackage

// File: rtl/muxirq_rr_pick.sv
`timescale 1ns/1ps
// Round-robin search: first set request after base_i, wrapping, base_i last.
module muxirq_rr_pick #(
    parameter int N  = 128,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] base_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    logic [IW-1:0] pos;

    // walk from the far end so the nearest candidate is written last
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        pos     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            pos = base_i + IW'(1) + IW'(i);
            if (req_i[pos]) begin
                found_o = 1'b1;
                idx_o   = pos;
            end
        end
    end

endmodule

// File: rtl/muxirq_flag_bank.sv
`timescale 1ns/1ps
// Event flag storage: one clear port, many set strobes; a set beats the clear.
module muxirq_flag_bank #(
    parameter int N  = 128,
    parameter int IW = $clog2(N)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  set_i,
    input  logic          clr_i,
    input  logic [IW-1:0] clr_idx_i,
    output logic [N-1:0]  flags_o
);

    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_i) begin
            flags_d[clr_idx_i] = 1'b0;
        end
        flags_d = flags_d | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/muxirq_rx_hold.sv
`timescale 1ns/1ps
// Per-line received character with pending and overrun status.
module muxirq_rx_hold #(
    parameter int NL = 32,
    parameter int CW = 8,
    parameter int LW = $clog2(NL)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NL-1:0]    stb_i,
    input  logic [NL*CW-1:0] char_i,
    input  logic             clr_i,
    input  logic [LW-1:0]    clr_line_i,
    input  logic [LW-1:0]    sel_line_i,
    output logic [CW-1:0]    sel_char_o,
    output logic             sel_ovr_o
);

    typedef struct packed {
        logic          pend;
        logic          ovr;
        logic [CW-1:0] chr;
    } line_t;

    line_t st_d [NL];
    line_t st_q [NL];

    // clear first, then a new arrival; overrun only if still pending
    always_comb begin
        for (int l = 0; l < NL; l++) begin
            st_d[l] = st_q[l];
            if (clr_i && (clr_line_i == LW'(l))) begin
                st_d[l].pend = 1'b0;
                st_d[l].ovr  = 1'b0;
            end
            if (stb_i[l]) begin
                st_d[l].ovr  = st_d[l].ovr | st_d[l].pend;
                st_d[l].pend = 1'b1;
                st_d[l].chr  = char_i[l*CW +: CW];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int l = 0; l < NL; l++) begin
                st_q[l] <= '0;
            end
        end else begin
            for (int l = 0; l < NL; l++) begin
                st_q[l] <= st_d[l];
            end
        end
    end

    assign sel_char_o = st_q[sel_line_i].chr;
    assign sel_ovr_o  = st_q[sel_line_i].ovr;

endmodule

// File: rtl/muxirq_scanner.sv
`timescale 1ns/1ps
module muxirq_scanner
    import muxirq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int CHAR_W    = 8
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_LINES-1:0]        rx_stb_i,
    input  logic [NUM_LINES*CHAR_W-1:0] rx_char_i,
    input  logic [NUM_LINES-1:0]        tx_done_i,
    input  logic [NUM_LINES-1:0]        carr_on_i,
    input  logic [NUM_LINES-1:0]        carr_off_i,
    input  logic                        rd_stb_i,
    output logic [CHAR_LSB+CHAR_W-1:0]  rd_word_o,
    output logic [EVT_TYPES-1:0]        irq_o
);

    localparam int LW     = $clog2(NUM_LINES);
    localparam int NF     = NUM_LINES * EVT_TYPES;
    localparam int IW     = $clog2(NF);
    localparam int WORD_W = CHAR_LSB + CHAR_W;

    typedef struct packed {
        logic          locked;
        logic [IW-1:0] ptr;
    } scan_t;

    scan_t scan_d, scan_q;

    logic [NF-1:0]     set_vec;
    logic [NF-1:0]     flags;
    logic              hit;
    logic [IW-1:0]     hit_idx;
    logic [TYPE_W-1:0] cur_type;
    logic [LW-1:0]     cur_line;
    logic              read_ok;
    logic              rx_clr;
    logic [CHAR_W-1:0] sel_char;
    logic              sel_ovr;

    // gather per-line strobes into flag order line*4 + kind
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_set
        assign set_vec[l*EVT_TYPES + int'(EV_RX)]       = rx_stb_i[l];
        assign set_vec[l*EVT_TYPES + int'(EV_TX)]       = tx_done_i[l];
        assign set_vec[l*EVT_TYPES + int'(EV_CARR_ON)]  = carr_on_i[l];
        assign set_vec[l*EVT_TYPES + int'(EV_CARR_OFF)] = carr_off_i[l];
    end

    assign cur_type = scan_q.ptr[TYPE_W-1:0];
    assign cur_line = scan_q.ptr[IW-1:TYPE_W];
    assign read_ok  = scan_q.locked && rd_stb_i;
    assign rx_clr   = read_ok && (cur_type == EV_RX);

    muxirq_flag_bank #(.N(NF), .IW(IW)) u_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_vec),
        .clr_i     (read_ok),
        .clr_idx_i (scan_q.ptr),
        .flags_o   (flags)
    );

    muxirq_rr_pick #(.N(NF), .IW(IW)) u_pick (
        .req_i   (flags),
        .base_i  (scan_q.ptr),
        .found_o (hit),
        .idx_o   (hit_idx)
    );

    muxirq_rx_hold #(.NL(NUM_LINES), .CW(CHAR_W), .LW(LW)) u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stb_i      (rx_stb_i),
        .char_i     (rx_char_i),
        .clr_i      (rx_clr),
        .clr_line_i (cur_line),
        .sel_line_i (cur_line),
        .sel_char_o (sel_char),
        .sel_ovr_o  (sel_ovr)
    );

    // lock until read; search only while unlocked
    always_comb begin
        scan_d = scan_q;
        if (scan_q.locked) begin
            if (rd_stb_i) begin
                scan_d.locked = 1'b0;
            end
        end else if (hit) begin
            scan_d.locked = 1'b1;
            scan_d.ptr    = hit_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    for (genvar t = 0; t < EVT_TYPES; t++) begin : g_irq
        assign irq_o[t] = scan_q.locked && (cur_type == TYPE_W'(t));
    end

    always_comb begin
        rd_word_o = '0;
        if (scan_q.locked) begin
            rd_word_o[LW-1:0] = cur_line;
            if (cur_type == EV_RX) begin
                rd_word_o[CHAR_LSB +: CHAR_W] = sel_char;
                rd_word_o[OVR_BIT]            = sel_ovr;
            end
        end
    end

endmodule

// File: rtl/muxirq_scanner_chk.sv
`timescale 1ns/1ps
module muxirq_scanner_chk #(
    parameter int LW     = 5,
    parameter int WORD_W = 24,
    parameter int NIRQ   = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_stb_i,
    input logic [WORD_W-1:0] rd_word_o,
    input logic [NIRQ-1:0]   irq_o
);

    assert_single_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_o));

    assert_lock_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_o != '0) && !rd_stb_i) |=> ($stable(irq_o) && $stable(rd_word_o[LW-1:0])));

    assert_read_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_o != '0) && rd_stb_i) |=> (irq_o == '0));

    assert_idle_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o == '0) |-> (rd_word_o == '0));

    assert_plain_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_o != '0) && !irq_o[0]) |-> (rd_word_o[WORD_W-1:LW] == '0));

endmodule

bind muxirq_scanner muxirq_scanner_chk #(
    .LW     (LW),
    .WORD_W (WORD_W),
    .NIRQ   (EVT_TYPES)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_stb_i  (rd_stb_i),
    .rd_word_o (rd_word_o),
    .irq_o     (irq_o)
);

// File: tb/muxirq_scanner_tb.sv
`timescale 1ns/1ps
module muxirq_scanner_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  rx_stb = '0;
    logic [255:0] rx_char = '0;
    logic [31:0]  tx_done = '0;
    logic [31:0]  carr_on = '0;
    logic [31:0]  carr_off = '0;
    logic         rd_stb = 1'b0;
    logic [23:0]  rd_word;
    logic [3:0]   irq;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    muxirq_scanner u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rx_stb_i   (rx_stb),
        .rx_char_i  (rx_char),
        .tx_done_i  (tx_done),
        .carr_on_i  (carr_on),
        .carr_off_i (carr_off),
        .rd_stb_i   (rd_stb),
        .rd_word_o  (rd_word),
        .irq_o      (irq)
    );

    // behavioural reference
    bit   m_flag [128];
    bit   m_pend [32];
    bit   m_ovr  [32];
    int   m_chr  [32];
    int   m_ptr;
    bit   m_lock;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 0;
            foreach (m_pend[i]) begin m_pend[i] = 0; m_ovr[i] = 0; m_chr[i] = 0; end
            m_ptr = 0;
            m_lock = 0;
        end else begin
            if (m_lock && rd_stb) begin
                m_flag[m_ptr] = 0;
                if (m_ptr % 4 == 0) begin
                    m_pend[m_ptr / 4] = 0;
                    m_ovr[m_ptr / 4] = 0;
                end
                m_lock = 0;
            end else if (!m_lock) begin
                for (int k = 1; k <= 128; k++) begin
                    if (m_flag[(m_ptr + k) % 128]) begin
                        m_ptr = (m_ptr + k) % 128;
                        m_lock = 1;
                        break;
                    end
                end
            end
            for (int l = 0; l < 32; l++) begin
                if (tx_done[l])  m_flag[l*4 + 1] = 1;
                if (carr_on[l])  m_flag[l*4 + 2] = 1;
                if (carr_off[l]) m_flag[l*4 + 3] = 1;
                if (rx_stb[l]) begin
                    m_flag[l*4] = 1;
                    if (m_pend[l]) m_ovr[l] = 1;
                    m_pend[l] = 1;
                    m_chr[l] = int'(rx_char[l*8 +: 8]);
                end
            end
        end
    end

    function automatic logic [3:0] model_irq();
        return m_lock ? 4'(1 << (m_ptr % 4)) : 4'h0;
    endfunction

    function automatic logic [23:0] model_word();
        int w;
        if (!m_lock) return 24'h0;
        w = m_ptr / 4;
        if (m_ptr % 4 == 0) w = w | (m_chr[m_ptr / 4] << 16) | (int'(m_ovr[m_ptr / 4]) << 15);
        return 24'(w);
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (irq !== model_irq() || rd_word !== model_word()) begin
                fails++;
                $display("FAIL %s model compare: irq=%h word=%h expected irq=%h word=%h",
                         cur_req, irq, rd_word, model_irq(), model_word());
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_in();
        rx_stb = '0; tx_done = '0; carr_on = '0; carr_off = '0;
    endtask

    task automatic read_once();
        rd_stb = 1'b1;
        next_cyc();
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) next_cyc();
        rst_n = 1'b1;
        next_cyc();
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 word after reset", 32'(rd_word), 32'h0);

        // R2 / R5: transmit done on line 5 -> flag 21, irq[1]
        cur_req = "R2";
        tx_done[5] = 1'b1;
        next_cyc();
        clear_in();
        chk("R2 irq one edge after flag", 32'(irq), 32'h0);
        next_cyc();
        chk("R2 irq kind transmit", 32'(irq), 32'h2);
        chk("R5 word line 5", 32'(rd_word), 32'd5);

        // R3: new event while locked does not disturb
        cur_req = "R3";
        carr_off[9] = 1'b1;
        next_cyc();
        clear_in();
        next_cyc();
        chk("R3 irq held during lock", 32'(irq), 32'h2);
        chk("R3 word held during lock", 32'(rd_word), 32'd5);

        // R7: read releases, then the recorded event follows
        cur_req = "R7";
        read_once();
        chk("R7 irq drops after read", 32'(irq), 32'h0);
        next_cyc();
        chk("R3 event recorded during lock", 32'(irq), 32'h8);
        chk("R5 word line 9", 32'(rd_word), 32'd9);
        read_once();
        next_cyc();
        chk("R7 idle after last read", 32'(irq), 32'h0);

        // R6: receive on line 3
        cur_req = "R6";
        rx_stb[3] = 1'b1;
        rx_char[3*8 +: 8] = 8'h41;
        next_cyc();
        clear_in();
        next_cyc();
        chk("R6 irq receive", 32'(irq), 32'h1);
        chk("R6 word char", 32'(rd_word), 32'h410003);

        // R8: second receive before read -> overrun, newest char
        cur_req = "R8";
        rx_stb[3] = 1'b1;
        rx_char[3*8 +: 8] = 8'h5A;
        next_cyc();
        clear_in();
        chk("R8 overrun and newest char", 32'(rd_word), 32'h5A8003);

        // R10: read coincides with a new receive on the same flag
        cur_req = "R10";
        rd_stb = 1'b1;
        rx_stb[3] = 1'b1;
        rx_char[3*8 +: 8] = 8'h33;
        next_cyc();
        rd_stb = 1'b0;
        clear_in();
        chk("R10 irq drops on read", 32'(irq), 32'h0);
        next_cyc();
        chk("R10 flag survives clear", 32'(irq), 32'h1);
        chk("R10 new char no overrun", 32'(rd_word), 32'h330003);
        cur_req = "R8";
        read_once();
        next_cyc();
        chk("R8 status cleared, scanner idle", 32'(irq), 32'h0);

        // R9 / R4: several strobes at once, pointer now 12
        cur_req = "R9";
        carr_on[0] = 1'b1;
        carr_off[31] = 1'b1;
        tx_done[10] = 1'b1;
        tx_done[3] = 1'b1;
        next_cyc();
        clear_in();
        next_cyc();
        chk("R4 nearest after pointer", 32'(irq), 32'h2);
        chk("R4 nearest line 3", 32'(rd_word), 32'd3);

        // R11: read held into the idle cycle must not delay the search
        cur_req = "R11";
        rd_stb = 1'b1;
        next_cyc();
        next_cyc();
        rd_stb = 1'b0;
        chk("R11 lock not delayed", 32'(irq), 32'h2);
        chk("R9 line 10 recorded", 32'(rd_word), 32'd10);
        cur_req = "R4";
        read_once();
        next_cyc();
        chk("R9 line 31 recorded", 32'(rd_word), 32'd31);
        chk("R4 carrier off kind", 32'(irq), 32'h8);
        read_once();
        next_cyc();
        chk("R4 wrap to line 0", 32'(rd_word), 32'd0);
        chk("R2 carrier on kind", 32'(irq), 32'h4);
        read_once();
        next_cyc();
        chk("R4 all serviced", 32'(irq), 32'h0);

        // R11: read with nothing pending
        cur_req = "R11";
        read_once();
        next_cyc();
        chk("R11 idle read ignored", 32'(irq), 32'h0);
        chk("R11 idle word", 32'(rd_word), 32'h0);

        // R1: reset discards pending flags
        cur_req = "R1";
        tx_done[7] = 1'b1;
        carr_off[8] = 1'b1;
        next_cyc();
        clear_in();
        next_cyc();
        rst_n = 1'b0;
        next_cyc();
        rst_n = 1'b1;
        repeat (3) next_cyc();
        chk("R1 flags dropped by reset", 32'(irq), 32'h0);

        // R4: flag 0 at the reset pointer is found after a full pass
        cur_req = "R4";
        rx_stb[0] = 1'b1;
        rx_char[0 +: 8] = 8'h7F;
        next_cyc();
        clear_in();
        next_cyc();
        chk("R4 pointer flag tested last", 32'(irq), 32'h1);
        chk("R6 line 0 char", 32'(rd_word), 32'h7F0000);
        read_once();
        next_cyc();
        chk("R7 final idle", 32'(irq), 32'h0);

        finish_run();
    end

endmodule